// File: doc/BRIEF.md
# Two-Phase Handshake Domain Bridge

This block carries single-word transactions from a clocked sender domain to a receiver domain over a request/acknowledge pair that uses transition signalling. A level change on either line is an event, whichever way it goes. The sender starts a transaction with a one-cycle send strobe. The request line then toggles, and the data word is captured into a bundle register. That register stays frozen until the answering acknowledge toggle has been seen. The receiver brings the request into its own clock through a flop chain and sees each toggle as a new transaction. It presents the word with a one-cycle valid pulse and holds a pending flag until local processing reports done. At that point the acknowledge line toggles.

Request and acknowledge alternate strictly. The sender accepts nothing new while a transaction is outstanding, and such a strobe is reported as an overrun. The receiver never acknowledges unless a request is pending. The two clocks may be unrelated. Each crossing signal passes through a synchronizer of `SYNC_STAGES` flops and then one XOR edge-detect flop.

Top module: `hs2p_bridge`

## Requirements
- R1: After reset, `hs_req` and `hs_ack` are low, `tx_ready` is high, and `rx_pending`, `rx_valid`, `tx_done` and `tx_overrun` are low.
- R2: A `tx_strobe` sampled while `tx_ready` is high toggles `hs_req` exactly once. `tx_ready` is low from the next cycle.
- R3: A `tx_strobe` sampled while `tx_ready` is low leaves `hs_req` and the bundled word unchanged. `tx_overrun` is high for the following cycle.
- R4: Each toggle of the request produces exactly one `rx_valid` pulse in the receiver clock. During that pulse `rx_data` equals the word given with the matching strobe, and `rx_pending` is high.
- R5: An `rx_done` sampled while `rx_pending` is high toggles `hs_ack` once and clears `rx_pending` on the next cycle. An `rx_done` sampled while `rx_pending` is low leaves `hs_ack` unchanged.
- R6: Each acknowledge toggle seen by the sender produces one `tx_done` pulse, and `tx_ready` is high again from the cycle of that pulse.
- R7: Both edge directions count. After the n-th accepted strobe, `hs_req` equals n modulo 2. After the n-th accepted `rx_done`, `hs_ack` equals n modulo 2. The first transaction therefore raises both lines and the second lowers both.
- R8: The bundled word crossing to the receiver holds still for the whole time `tx_ready` is low.
- R9: Each crossing line is resynchronised through `SYNC_STAGES` (at least 2) flops before its edge detector. With 2 stages, a request toggle shows up as `rx_valid` on the third receiver clock edge after it.
- R10: With unrelated clocks, every accepted strobe is delivered once, in order, with its data intact. The count of `tx_done` pulses equals the count of accepted strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Sender domain clock |
| tx_rst_n | input | 1 | Sender domain reset, active low |
| tx_strobe | input | 1 | One-cycle request to send `tx_data` |
| tx_data | input | DATA_W | Word to send |
| tx_ready | output | 1 | Sender can accept a strobe |
| tx_done | output | 1 | One-cycle pulse: the acknowledge for the outstanding word has arrived |
| tx_overrun | output | 1 | One-cycle pulse: a strobe arrived while busy and was dropped |
| rx_clk | input | 1 | Receiver domain clock |
| rx_rst_n | input | 1 | Receiver domain reset, active low |
| rx_done | input | 1 | Local processing finished with the pending word |
| rx_valid | output | 1 | One-cycle pulse: a new word is on `rx_data` |
| rx_data | output | DATA_W | Received word, held until the next one |
| rx_pending | output | 1 | A received word awaits `rx_done` |
| hs_req | output | 1 | Request line level (transition signalled) |
| hs_ack | output | 1 | Acknowledge line level (transition signalled) |

## Verification
The bench builds the bridge with `DATA_W = 8` and `SYNC_STAGES = 3`, which makes each crossing one flop deeper than the default. It runs the sender at 4 ns against a receiver at an unrelated 7 ns period, so the request and acknowledge toggles land at every phase of the far clock. Random gaps and receiver delays down to zero reach the back-to-back case, where a strobe is issued in the first ready cycle and done is given in the same cycle as valid. Overrun strobes injected mid-transaction and stray done pulses issued right after an acknowledge exercise the rejection paths on both sides.

// File: rtl/hs2p_pkg.sv
package hs2p_pkg;

  // An event has occurred when the freshly synchronised level differs
  // from the level last recorded.
  function automatic logic toggle_seen(input logic now_lvl, input logic prev_lvl);
    return now_lvl ^ prev_lvl;
  endfunction

  // One side owes the other a reply while their line levels disagree.
  function automatic logic levels_differ(input logic mine, input logic theirs);
    return mine != theirs;
  endfunction

  // Level a transition-signalled line shows after a number of events.
  function automatic logic level_after(input int unsigned events);
    return events[0];
  endfunction

endpackage

// File: rtl/hs2p_sync.sv
module hs2p_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/hs2p_toggle_det.sv
module hs2p_toggle_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic event_out,
  output logic level_seen
);
  import hs2p_pkg::*;

  logic synced;
  logic prev_q;

  hs2p_sync #(.STAGES(STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (line_in),
    .sync_out (synced)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;
  end

  assign event_out  = toggle_seen(synced, prev_q);
  assign level_seen = prev_q;
endmodule

// File: rtl/hs2p_tx_side.sv
module hs2p_tx_side #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [DATA_W-1:0] data_in,
  input  logic              ack_line,
  output logic              req_line,
  output logic [DATA_W-1:0] bundle,
  output logic              ready,
  output logic              done,
  output logic              overrun,
  output logic              ack_evt
);
  import hs2p_pkg::*;

  logic              req_q;
  logic [DATA_W-1:0] bundle_q;
  logic              done_q;
  logic              overrun_q;
  logic              ack_level;
  logic              accept;

  hs2p_toggle_det #(.STAGES(SYNC_STAGES)) ack_det_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (ack_line),
    .event_out  (ack_evt),
    .level_seen (ack_level)
  );

  assign ready  = !levels_differ(req_q, ack_level);
  assign accept = strobe && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      bundle_q  <= '0;
      done_q    <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      done_q    <= ack_evt;
      overrun_q <= strobe && !ready;
      if (accept) begin
        req_q    <= !req_q;
        bundle_q <= data_in;
      end
    end
  end

  assign req_line = req_q;
  assign bundle   = bundle_q;
  assign done     = done_q;
  assign overrun  = overrun_q;
endmodule

// File: rtl/hs2p_rx_side.sv
module hs2p_rx_side #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_line,
  input  logic [DATA_W-1:0] bundle,
  input  logic              done_in,
  output logic              ack_line,
  output logic              valid,
  output logic [DATA_W-1:0] data_out,
  output logic              pending,
  output logic              req_evt
);
  import hs2p_pkg::*;

  logic              ack_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              req_level;
  logic              reply;

  hs2p_toggle_det #(.STAGES(SYNC_STAGES)) req_det_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (req_line),
    .event_out  (req_evt),
    .level_seen (req_level)
  );

  assign pending = levels_differ(req_level, ack_q);
  assign reply   = done_in && pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= req_evt;
      if (req_evt) data_q <= bundle;
      if (reply)   ack_q  <= !ack_q;
    end
  end

  assign ack_line = ack_q;
  assign valid    = valid_q;
  assign data_out = data_q;
endmodule

// File: rtl/hs2p_bridge.sv
module hs2p_bridge #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              tx_clk,
  input  logic              tx_rst_n,
  input  logic              tx_strobe,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              tx_done,
  output logic              tx_overrun,
  input  logic              rx_clk,
  input  logic              rx_rst_n,
  input  logic              rx_done,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_pending,
  output logic              hs_req,
  output logic              hs_ack
);
  localparam int SYNC_DEPTH = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [DATA_W-1:0] link_data;
  logic              tx_ack_evt;
  logic              rx_req_evt;

  hs2p_tx_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_DEPTH)) tx_i (
    .clk      (tx_clk),
    .rst_n    (tx_rst_n),
    .strobe   (tx_strobe),
    .data_in  (tx_data),
    .ack_line (hs_ack),
    .req_line (hs_req),
    .bundle   (link_data),
    .ready    (tx_ready),
    .done     (tx_done),
    .overrun  (tx_overrun),
    .ack_evt  (tx_ack_evt)
  );

  hs2p_rx_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_DEPTH)) rx_i (
    .clk      (rx_clk),
    .rst_n    (rx_rst_n),
    .req_line (hs_req),
    .bundle   (link_data),
    .done_in  (rx_done),
    .ack_line (hs_ack),
    .valid    (rx_valid),
    .data_out (rx_data),
    .pending  (rx_pending),
    .req_evt  (rx_req_evt)
  );
endmodule

// File: rtl/hs2p_bridge_chk.sv
module hs2p_bridge_chk #(
  parameter int DATA_W = 8
) (
  input logic              tx_clk,
  input logic              tx_rst_n,
  input logic              tx_strobe,
  input logic              tx_ready,
  input logic              tx_done,
  input logic              tx_overrun,
  input logic              tx_ack_evt,
  input logic [DATA_W-1:0] link_data,
  input logic              hs_req,
  input logic              rx_clk,
  input logic              rx_rst_n,
  input logic              rx_done,
  input logic              rx_valid,
  input logic              rx_pending,
  input logic              rx_req_evt,
  input logic              hs_ack
);
  // R2
  accept_drops_ready_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    tx_strobe && tx_ready |=> !tx_ready);
  // R2
  accept_toggles_req_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    tx_strobe && tx_ready |=> hs_req != $past(hs_req));
  // R3
  overrun_flag_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    tx_strobe && !tx_ready |=> tx_overrun);
  // R3
  busy_req_hold_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    !tx_ready |=> $stable(hs_req));
  // R8
  bundle_hold_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    !tx_ready |=> $stable(link_data));
  // R6
  ack_frees_sender_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    tx_ack_evt |=> tx_ready && tx_done);
  // R4
  req_gives_valid_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    rx_req_evt |=> rx_valid);
  // R4
  valid_is_pending_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    rx_valid |-> rx_pending);
  // R5
  stray_done_ignored_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    rx_done && !rx_pending |=> $stable(hs_ack));
  // R5
  done_acks_once_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    rx_done && rx_pending |=> !rx_pending && hs_ack != $past(hs_ack));
endmodule

bind hs2p_bridge hs2p_bridge_chk #(.DATA_W(DATA_W)) chk_i (
  .tx_clk     (tx_clk),
  .tx_rst_n   (tx_rst_n),
  .tx_strobe  (tx_strobe),
  .tx_ready   (tx_ready),
  .tx_done    (tx_done),
  .tx_overrun (tx_overrun),
  .tx_ack_evt (tx_ack_evt),
  .link_data  (link_data),
  .hs_req     (hs_req),
  .rx_clk     (rx_clk),
  .rx_rst_n   (rx_rst_n),
  .rx_done    (rx_done),
  .rx_valid   (rx_valid),
  .rx_pending (rx_pending),
  .rx_req_evt (rx_req_evt),
  .hs_ack     (hs_ack)
);

// File: tb/hs2p_bridge_tb_top.sv
module hs2p_bridge_tb_top;
  localparam int DW      = 8;
  localparam int NTRANS  = 60;
  localparam int WD_CYC  = 150000;

  logic          tx_clk = 1'b0;
  logic          rx_clk = 1'b0;
  logic          tx_rst_n = 1'b0;
  logic          rx_rst_n = 1'b0;
  logic          tx_strobe = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic          rx_done = 1'b0;
  logic          tx_ready, tx_done, tx_overrun;
  logic          rx_valid, rx_pending, hs_req, hs_ack;
  logic [DW-1:0] rx_data;

  int checks = 0;
  int failures = 0;
  int sent = 0;
  int got = 0;
  int acks = 0;
  int done_pulses = 0;
  bit finished = 0;
  logic [DW-1:0] exp_q [0:NTRANS-1];

  always #2 tx_clk = ~tx_clk;
  always #3.5 rx_clk = ~rx_clk;

  hs2p_bridge #(.DATA_W(DW), .SYNC_STAGES(3)) dut_i (
    .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .tx_strobe(tx_strobe), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_done(tx_done), .tx_overrun(tx_overrun),
    .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_done(rx_done),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_pending(rx_pending),
    .hs_req(hs_req), .hs_ack(hs_ack)
  );

  function automatic logic exp_level(input int n);
    return (n % 2) == 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge tx_clk) if (tx_rst_n && tx_done) done_pulses++;

  task automatic tx_proc();
    for (int i = 0; i < NTRANS; i++) begin
      int gap = $urandom_range(0, 3);
      logic [DW-1:0] d = DW'($urandom);
      repeat (gap) @(negedge tx_clk);
      while (!tx_ready) @(negedge tx_clk);
      exp_q[i] = d;
      tx_strobe = 1'b1; tx_data = d;
      @(negedge tx_clk);
      tx_strobe = 1'b0;
      sent++;
      check(!tx_ready, "R2 ready low after accept", tx_ready, 0);
      check(hs_req == exp_level(sent), "R7 req level", hs_req, exp_level(sent));
      if (i % 3 == 1) begin
        logic rq = hs_req;
        tx_strobe = 1'b1; tx_data = ~d;
        @(negedge tx_clk);
        tx_strobe = 1'b0;
        check(tx_overrun == 1'b1, "R3 overrun flagged", tx_overrun, 1);
        check(hs_req == rq, "R3 req unchanged", hs_req, rq);
      end
    end
    while (!tx_ready) @(negedge tx_clk);
  endtask

  task automatic rx_proc();
    while (got < NTRANS) begin
      @(negedge rx_clk);
      if (rx_valid) begin
        int dly = $urandom_range(0, 6);
        check(rx_data == exp_q[got], "R4 data order", rx_data, exp_q[got]);
        check(rx_pending, "R4 pending with valid", rx_pending, 1);
        got++;
        if (dly == 0) begin
          rx_done = 1'b1;
        end else begin
          repeat (dly - 1) @(negedge rx_clk);
          rx_done = 1'b1;
        end
        @(negedge rx_clk);
        rx_done = 1'b0;
        acks++;
        check(!rx_pending, "R5 pending cleared", rx_pending, 0);
        check(hs_ack == exp_level(acks), "R7 ack level", hs_ack, exp_level(acks));
        rx_done = 1'b1;
        @(negedge rx_clk);
        rx_done = 1'b0;
        check(hs_ack == exp_level(acks), "R5 stray done ignored", hs_ack, exp_level(acks));
      end
    end
  endtask

  task automatic latency_probe();
    // R9: with 3 stages the request shows as rx_valid on the 4th rx edge
    int edges = 0;
    while (!tx_ready) @(negedge tx_clk);
    @(negedge rx_clk);
    tx_strobe = 1'b1; tx_data = 8'hA5;
    @(posedge tx_clk);
    #0.5 tx_strobe = 1'b0;
    while (!rx_valid && edges < 20) begin
      @(negedge rx_clk);
      edges++;
    end
    check(rx_valid && rx_data == 8'hA5, "R9 probe delivered", rx_data, 8'hA5);
    check(edges >= 4 && edges <= 5, "R9 sync latency", edges, 4);
    rx_done = 1'b1;
    @(negedge rx_clk);
    rx_done = 1'b0;
    while (!tx_ready) @(negedge tx_clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge tx_clk);
    tx_rst_n = 1'b1; rx_rst_n = 1'b1;
    @(negedge tx_clk);
    check(hs_req == 0 && hs_ack == 0, "R1 lines low", {hs_req, hs_ack}, 0);
    check(tx_ready == 1, "R1 ready", tx_ready, 1);
    check(!rx_pending && !rx_valid && !tx_done && !tx_overrun, "R1 flags low",
          {rx_pending, rx_valid, tx_done, tx_overrun}, 0);
    // R5: done with nothing pending leaves ack low
    @(negedge rx_clk); rx_done = 1'b1;
    @(negedge rx_clk); rx_done = 1'b0;
    check(hs_ack == 0, "R5 done before any request", hs_ack, 0);
    fork
      tx_proc();
      rx_proc();
    join
    repeat (10) @(negedge tx_clk);
    check(got == sent, "R10 no loss", got, sent);
    check(done_pulses == sent, "R6 one tx_done per ack", done_pulses, sent);
    latency_probe();
    repeat (10) @(negedge tx_clk);
    check(done_pulses == sent + 1, "R6 probe acknowledged", done_pulses, sent + 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge tx_clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", got, NTRANS);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule